// File: doc/BRIEF.md
# Debug Register Lock and Claim Guard

This block sits in front of the register file of a debug component and decides whether each bus write reaches it. A software lock stops code under debug from changing the component by accident. Accesses marked as coming from an external debugger skip the lock and can always write. The block also holds a small claim-tag register. Cooperating agents use it to mark who owns the component. It has separate set and clear locations, and each location returns something different on a read.

The lock is a two-state machine. `LK_LOCKED` is the reset state. `LK_OPEN` is the unlocked state. There are four transitions:

- *unlock*: `LK_LOCKED` to `LK_OPEN`, when the key is written to the lock-key location.
- *relock*: `LK_OPEN` to `LK_LOCKED`, when any other value is written there.
- *stay-locked*: the machine remains in `LK_LOCKED` when a non-key value is written while locked.
- *stay-open*: the machine remains in `LK_OPEN` when the key is written again while open.

Every access is single-cycle. `grd_wr_permit` and `grd_rdata` are combinational from the current access. Any state change appears after the next rising clock edge. The protected register file uses `grd_wr_permit` as its write enable. The four guard locations never raise `grd_wr_permit`.

Top module: `dbg_access_guard`

## Requirements
- R1: After reset the lock is in `LK_LOCKED` and all four claim bits are 0.
- R2: A write of 0xC5ACCE55 to the lock-key location (offset 0xFB0) moves the lock to `LK_OPEN`. The new state applies from the next cycle. That key write itself never raises `grd_wr_permit`.
- R3: A write of any other value to offset 0xFB0 moves the lock to `LK_LOCKED` from the next cycle. This holds in either state. The lock state does not change without a write to 0xFB0.
- R4: While locked, every write without the debugger flag is rejected, except a write to 0xFB0. A rejected write keeps `grd_wr_permit` low, leaves the claim bits unchanged and raises no error.
- R5: A write with `acc_dbg` high ignores the lock. It raises `grd_wr_permit` for any offset that is not a guard location, and it updates the claim bits.
- R6: A read of the lock-status location (offset 0xFB4) with `acc_dbg` high returns 0.
- R7: A read of 0xFB4 with `acc_dbg` low returns bit 0 = 1 (a lock exists) and bit 1 = 1 when locked. All other bits are 0. This gives 0x3 when locked and 0x1 when open.
- R8: A permitted write to the claim-set location (offset 0xFA0) sets each claim bit whose `acc_wdata[3:0]` bit is 1. Write bits above bit 3 are ignored. A read of 0xFA0 returns 0xF, the mask of implemented claim bits.
- R9: A permitted write to the claim-clear location (offset 0xFA4) clears each claim bit whose `acc_wdata[3:0]` bit is 1. A read of 0xFA4 returns the current claim bits in bits 3:0, with all upper bits 0.
- R10: Each of the following keeps `grd_wr_permit` low:
  - a read;
  - an access with `acc_valid` low;
  - any access to the four guard locations.

  A write to 0xFB4 changes nothing. A read of 0xFB0 returns 0. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dbg | input | 1 | Access originates from the external debugger |
| acc_addr | input | 12 | Byte offset within the component frame |
| acc_wdata | input | 32 | Write data |
| grd_rdata | output | 32 | Read data for guard locations, 0 otherwise |
| grd_wr_permit | output | 1 | Write enable for the protected register file |

## Verification
Two things can act in the same cycle: a lock transition and the permit decision for the access that follows it. The lock decision also coincides with a claim update on one access. The bench drives a key write and then, in the very next cycle, a plain write. The key cycle must show the permit low and the following cycle must show it high. It repeats the pattern with a relock, where the plain write that follows must be refused. It also sends claim writes while locked, from both origins. The claim value read back afterwards shows whether the lock decision and the claim update were combined correctly in that cycle.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;

    typedef enum logic [0:0] {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    // Which guard location the current access hits
    typedef struct packed {
        logic key;
        logic stat;
        logic cset;
        logic cclr;
    } guard_hit_t;

endpackage

// File: rtl/guard_lock_fsm.sv
module guard_lock_fsm
    import dbg_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_match,
    output logic locked
);

    lock_state_e state_q;
    lock_state_e state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr && key_match)  state_d = LK_OPEN;    // unlock
            LK_OPEN:   if (key_wr && !key_match) state_d = LK_LOCKED;  // relock
            default:   state_d = LK_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            LK_LOCKED: locked = 1'b1;
            LK_OPEN:   locked = 1'b0;
            default:   locked = 1'b1;
        endcase
    end

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_match) |=> !locked);

    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match) |=> locked);

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(locked));

endmodule

// File: rtl/guard_claim_bank.sv
module guard_claim_bank #(
    parameter int CLAIM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [CLAIM_W-1:0] wbits,
    output logic [CLAIM_W-1:0] claim
);

    for (genvar b = 0; b < CLAIM_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   claim[b] <= 1'b0;
            else if (set_we && wbits[b])  claim[b] <= 1'b1;
            else if (clr_we && wbits[b])  claim[b] <= 1'b0;
        end
    end

    p_set_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((claim & $past(wbits)) == $past(wbits)));

    p_clr_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((claim & $past(wbits)) == '0));

    p_claim_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(claim));

endmodule

// File: rtl/guard_decode.sv
module guard_decode
    import dbg_guard_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFS_KEY  = 12'hFB0,
    parameter logic [ADDR_W-1:0] OFS_STAT = 12'hFB4,
    parameter logic [ADDR_W-1:0] OFS_CSET = 12'hFA0,
    parameter logic [ADDR_W-1:0] OFS_CCLR = 12'hFA4
) (
    input  logic              valid,
    input  logic              write,
    input  logic              dbg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              locked,
    output guard_hit_t        hit,
    output logic              key_wr,
    output logic              set_we,
    output logic              clr_we,
    output logic              wr_permit
);

    logic wr_go;
    logic may_write;

    always_comb begin
        hit.key   = (addr == OFS_KEY);
        hit.stat  = (addr == OFS_STAT);
        hit.cset  = (addr == OFS_CSET);
        hit.cclr  = (addr == OFS_CCLR);
        wr_go     = valid && write;
        may_write = dbg || !locked;
        key_wr    = wr_go && hit.key;
        set_we    = wr_go && may_write && hit.cset;
        clr_we    = wr_go && may_write && hit.cclr;
        wr_permit = wr_go && may_write && (hit == '0);
    end

endmodule

// File: rtl/guard_read_mux.sv
module guard_read_mux
    import dbg_guard_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CLAIM_W = 4
) (
    input  logic               valid,
    input  logic               write,
    input  logic               dbg,
    input  guard_hit_t         hit,
    input  logic               locked,
    input  logic [CLAIM_W-1:0] claim,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [DATA_W-1:0] CLAIM_MASK =
        {{(DATA_W-CLAIM_W){1'b0}}, {CLAIM_W{1'b1}}};

    always_comb begin
        rdata = '0;
        if (valid && !write) begin
            if (hit.cset)
                rdata = CLAIM_MASK;
            else if (hit.cclr)
                rdata = {{(DATA_W-CLAIM_W){1'b0}}, claim};
            else if (hit.stat && !dbg)
                rdata = {{(DATA_W-2){1'b0}}, locked, 1'b1};
        end
    end

endmodule

// File: rtl/dbg_access_guard.sv
module dbg_access_guard
    import dbg_guard_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter int                CLAIM_W    = 4,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55,
    parameter logic [ADDR_W-1:0] OFS_KEY    = 12'hFB0,
    parameter logic [ADDR_W-1:0] OFS_STAT   = 12'hFB4,
    parameter logic [ADDR_W-1:0] OFS_CSET   = 12'hFA0,
    parameter logic [ADDR_W-1:0] OFS_CCLR   = 12'hFA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_dbg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] grd_rdata,
    output logic              grd_wr_permit
);

    localparam logic [DATA_W-1:0] CLAIM_MASK =
        {{(DATA_W-CLAIM_W){1'b0}}, {CLAIM_W{1'b1}}};

    guard_hit_t         hit;
    logic               locked;
    logic               key_wr;
    logic               key_match;
    logic               set_we;
    logic               clr_we;
    logic [CLAIM_W-1:0] claim;

    assign key_match = (acc_wdata == UNLOCK_KEY);

    guard_decode #(
        .ADDR_W(ADDR_W), .OFS_KEY(OFS_KEY), .OFS_STAT(OFS_STAT),
        .OFS_CSET(OFS_CSET), .OFS_CCLR(OFS_CCLR)
    ) u_decode (
        .valid(acc_valid), .write(acc_write), .dbg(acc_dbg), .addr(acc_addr),
        .locked(locked), .hit(hit), .key_wr(key_wr), .set_we(set_we),
        .clr_we(clr_we), .wr_permit(grd_wr_permit)
    );

    guard_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key_match(key_match), .locked(locked)
    );

    guard_claim_bank #(.CLAIM_W(CLAIM_W)) u_claim (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .wbits(acc_wdata[CLAIM_W-1:0]), .claim(claim)
    );

    guard_read_mux #(.DATA_W(DATA_W), .CLAIM_W(CLAIM_W)) u_rmux (
        .valid(acc_valid), .write(acc_write), .dbg(acc_dbg), .hit(hit),
        .locked(locked), .claim(claim), .rdata(grd_rdata)
    );

    p_locked_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_dbg && locked) |-> !grd_wr_permit);

    p_claim_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_dbg && locked && acc_addr != OFS_KEY)
        |=> $stable(claim));

    p_dbg_permit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_dbg && acc_addr != OFS_KEY &&
         acc_addr != OFS_STAT && acc_addr != OFS_CSET && acc_addr != OFS_CCLR)
        |-> grd_wr_permit);

    p_dbg_stat_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_dbg && acc_addr == OFS_STAT)
        |-> (grd_rdata == '0));

    p_stat_lockbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_dbg && acc_addr == OFS_STAT)
        |-> (grd_rdata[0] && grd_rdata[1] == locked));

    p_cset_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr == OFS_CSET)
        |-> (grd_rdata == CLAIM_MASK));

    p_read_no_permit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |-> !grd_wr_permit);

endmodule

// File: tb/dbg_access_guard_test.sv
`timescale 1ns/1ps
module dbg_access_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_dbg = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] grd_rdata;
    logic        grd_wr_permit;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    typedef struct packed {
        logic        v;
        logic        w;
        logic        d;
        logic [11:0] a;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        pm;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1,0,0,12'hFB4,32'h0,32'h3,0,4'd1},       // R1 locked after reset
        '{1,0,0,12'hFA4,32'h0,32'h0,0,4'd1},       // R1 claim 0
        '{1,1,0,12'h100,32'hAA,32'h0,0,4'd4},      // R4 blocked
        '{1,1,0,12'hFA0,32'h5,32'h0,0,4'd4},       // R4 claim set rejected
        '{1,0,0,12'hFA4,32'h0,32'h0,0,4'd4},       // R4 claim unchanged
        '{1,1,1,12'h100,32'hAA,32'h0,1,4'd5},      // R5 debugger passes
        '{1,1,1,12'hFA0,32'h3,32'h0,0,4'd5},       // R5 debugger claim set
        '{1,0,0,12'hFA4,32'h0,32'h3,0,4'd5},       // R5 claim now 3
        '{1,0,1,12'hFB4,32'h0,32'h0,0,4'd6},       // R6 debugger status 0
        '{1,1,0,12'hFB0,KEY,32'h0,0,4'd2},         // R2 unlock key
        '{1,0,0,12'hFB4,32'h0,32'h1,0,4'd7},       // R7 open status
        '{1,1,0,12'h100,32'h1,32'h0,1,4'd10},      // R10 open write permitted
        '{1,0,0,12'h100,32'h0,32'h0,0,4'd10},      // R10 read no permit
        '{1,1,0,12'hFA0,32'hC,32'h0,0,4'd8},       // R8 set -> F
        '{1,0,0,12'hFA0,32'h0,32'hF,0,4'd8},       // R8 mask read
        '{1,0,0,12'hFA4,32'h0,32'hF,0,4'd9},       // R9 value F
        '{1,1,0,12'hFA4,32'h5,32'h0,0,4'd9},       // R9 clear -> A
        '{1,0,0,12'hFA4,32'h0,32'hA,0,4'd9},       // R9 value A
        '{1,1,0,12'hFA0,32'hFFFFFFF0,32'h0,0,4'd8},// R8 upper bits ignored
        '{1,0,0,12'hFA4,32'h0,32'hA,0,4'd8},       // R8 still A
        '{1,1,0,12'hFB4,32'h0,32'h0,0,4'd10},      // R10 status write ignored
        '{1,0,0,12'hFB4,32'h0,32'h1,0,4'd10},      // R10 still open
        '{1,0,0,12'hFB0,32'h0,32'h0,0,4'd10},      // R10 key reads 0
        '{1,1,0,12'hFB0,32'h12345678,32'h0,0,4'd3},// R3 relock
        '{1,0,0,12'hFB4,32'h0,32'h3,0,4'd3},       // R3 locked status
        '{1,1,0,12'hFA4,32'hF,32'h0,0,4'd4},       // R4 clear rejected
        '{1,0,0,12'hFA4,32'h0,32'hA,0,4'd4},       // R4 claim kept
        '{0,1,1,12'h100,32'h1,32'h0,0,4'd10}       // R10 no valid
    };

    dbg_access_guard uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_dbg(acc_dbg), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .grd_rdata(grd_rdata), .grd_wr_permit(grd_wr_permit)
    );

    always #2 clk = ~clk;

    task automatic chk(input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic d,
                         input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_dbg = d; acc_addr = a; acc_wdata = wd;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].v, VEC[i].w, VEC[i].d, VEC[i].a, VEC[i].wd);
            chk(int'(VEC[i].rq), $sformatf("vec %0d rdata", i), grd_rdata, VEC[i].rd);
            chk(int'(VEC[i].rq), $sformatf("vec %0d permit", i),
                {31'b0, grd_wr_permit}, {31'b0, VEC[i].pm});
        end

        // R2 collision: key write, then a plain write the very next cycle
        drive(1, 1, 0, 12'hFB0, KEY);
        chk(2, "permit during key write", {31'b0, grd_wr_permit}, 32'h0);
        drive(1, 1, 0, 12'h200, 32'h7);
        chk(2, "permit right after unlock", {31'b0, grd_wr_permit}, 32'h1);
        // R3 collision: relock, then a plain write next cycle
        drive(1, 1, 0, 12'hFB0, 32'h0);
        chk(3, "permit during relock", {31'b0, grd_wr_permit}, 32'h0);
        drive(1, 1, 0, 12'h200, 32'h7);
        chk(3, "permit right after relock", {31'b0, grd_wr_permit}, 32'h0);
        // R5 debugger claim clear while locked
        drive(1, 1, 1, 12'hFA4, 32'h2);
        drive(1, 0, 0, 12'hFA4, 32'h0);
        chk(5, "debugger clear while locked", grd_rdata, 32'h8);
        // R3 key written again while open keeps it open
        drive(1, 1, 0, 12'hFB0, KEY);
        drive(1, 1, 0, 12'hFB0, KEY);
        drive(1, 0, 0, 12'hFB4, 32'h0);
        chk(3, "double key stays open", grd_rdata, 32'h1);

        // R1 reset mid-run
        drive(0, 0, 0, 12'h0, 32'h0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 0, 0, 12'hFB4, 32'h0);
        chk(1, "status after reset", grd_rdata, 32'h3);
        drive(1, 0, 0, 12'hFA4, 32'h0);
        chk(1, "claim after reset", grd_rdata, 32'h0);
        drive(0, 0, 0, 12'h0, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule